// File: doc/BRIEF.md
# Packed Addressable Status Store

This block keeps the most recent 2-bit flow-control status of every channel in a small word-organised store. A channel-tagged status stream arrives one entry per clock, together with a qualifier that is high only on cycles carrying real channel status. Cycles spent on framing or parity carry no status, and the qualifier is low on them. Each qualified entry overwrites the stored status of its channel. The rest of the store is left alone.

The statuses are packed sixteen to a 32-bit word. The upper bits of the channel number select the word, and the lower bits select a 2-bit field inside it. A user reads any word at random through a word address, and the read data arrives one clock later. The store and the reader share the status receive clock.

A user can tie the read address to the upper bits of the incoming channel number. The read port then shows, live, the word that is being updated, including the field written in that same cycle.

Top module: `stat_store`

## Requirements
- R1: After reset every stored field holds the starving code 00, so every word reads as 0, and the read data output is 0.
- R2: Channel n is held in word n[7:4], in bits [2k+1:2k] with k = n[3:0]. For example, channel 1 is in bits [3:2] of word 0, and channel 16 is in bits [1:0] of word 1.
- R3: A qualified update changes only the addressed 2-bit field. The other fifteen fields of that word keep their values.
- R4: A cycle with the status qualifier low changes no stored field.
- R5: Read data is registered. The word for an address presented before a clock edge appears on the output after that edge, and the output holds its previous value until then.
- R6: When a qualified update and the read address hit the same word in the same cycle, the read returns the word with the new field already in it (write-first).
- R7: A qualified update to one word does not disturb a read of a different word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Status receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | High on cycles carrying real channel status |
| in_chan | input | 8 | Channel number of the incoming status |
| in_stat | input | 2 | Incoming 2-bit status |
| rd_addr | input | 4 | Word address to read |
| rd_word | output | 32 | Registered read data, sixteen packed fields |

## Verification
A corrupted field, a write to the wrong lane, or a write on an unqualified cycle shows up on rd_word as soon as that word is read. The read data appears one edge after the address. The bench keeps a per-channel model of the store and reads on every cycle, mostly at random addresses, so a wrong internal state is usually reported within a few cycles. The live-view case, where the read address follows the incoming channel, checks write-first forwarding on the same edge as the update.

// File: rtl/stat_store.sv
module stat_store #(
  parameter int CH_W   = 8,
  parameter int ST_W   = 2,
  parameter int FIELDS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [CH_W-1:0]                   in_chan,
  input  logic [ST_W-1:0]                   in_stat,
  input  logic [CH_W-$clog2(FIELDS)-1:0]    rd_addr,
  output logic [FIELDS*ST_W-1:0]            rd_word
);
  localparam int FLD_W  = $clog2(FIELDS);
  localparam int ADDR_W = CH_W - FLD_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = FIELDS * ST_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] merged;

  wire [ADDR_W-1:0] wa = in_chan[CH_W-1:FLD_W];
  wire [FLD_W-1:0]  fi = in_chan[FLD_W-1:0];
  wire              hit = in_valid && (wa == rd_addr);

  always_comb begin
    merged = mem[wa];
    merged[fi*ST_W +: ST_W] = in_stat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_word <= '0;
    end else begin
      if (in_valid) mem[wa] <= merged;
      rd_word <= hit ? merged : mem[rd_addr];
    end
  end
endmodule

module stat_store_chk #(
  parameter int CH_W   = 8,
  parameter int ST_W   = 2,
  parameter int FIELDS = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [CH_W-1:0]                in_chan,
  input logic [ST_W-1:0]                in_stat,
  input logic [CH_W-$clog2(FIELDS)-1:0] rd_addr,
  input logic [FIELDS*ST_W-1:0]         rd_word
);
  localparam int FLD_W  = $clog2(FIELDS);
  localparam int WORD_W = FIELDS * ST_W;

  wire same_word = rd_addr == in_chan[CH_W-1:FLD_W];

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $stable(rd_addr)) |=> $stable(rd_word));

  // R6
  write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && same_word) |=>
      ((rd_word >> (ST_W * $past(in_chan[FLD_W-1:0]))) & {{(WORD_W-ST_W){1'b0}}, {ST_W{1'b1}}})
        == {{(WORD_W-ST_W){1'b0}}, $past(in_stat)});

  // R3
  field_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && same_word && $stable(rd_addr)) |=>
      (((rd_word ^ $past(rd_word)) &
        ~({{(WORD_W-ST_W){1'b0}}, {ST_W{1'b1}}} << (ST_W * $past(in_chan[FLD_W-1:0])))) == '0));

  // R7
  other_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !same_word && $stable(rd_addr)) |=> $stable(rd_word));
endmodule

bind stat_store stat_store_chk #(.CH_W(CH_W), .ST_W(ST_W), .FIELDS(FIELDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
  .in_stat(in_stat), .rd_addr(rd_addr), .rd_word(rd_word)
);

// File: tb/sim_stat_store.sv
module sim_stat_store;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_chan = '0;
  logic [1:0]  in_stat = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_word;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [1:0]  model [256];
  logic [31:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  stat_store u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
                 .in_stat(in_stat), .rd_addr(rd_addr), .rd_word(rd_word));

  function automatic logic [31:0] pack(input logic [3:0] a);
    logic [31:0] w;
    for (int k = 0; k < 16; k++) w[2*k +: 2] = model[a*16 + k];
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] ch, input logic [1:0] st,
                      input logic [3:0] ra, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    in_valid = v; in_chan = ch; in_stat = st; rd_addr = ra;
    #0.5;
    check("R5 hold before edge", rd_word, prev_exp);
    if (v) model[ch] = st;
    exp = pack(ra);
    @(posedge clk); #1;
    check(tag, rd_word, exp);
    prev_exp = exp;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 2'b00;
    repeat (4) @(posedge clk);
    #1;
    check("R1 output after reset", rd_word, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 16; a++) step(1'b0, 8'h00, 2'b11, a[3:0], "R1 word cleared");
    // R2 packing
    step(1'b1, 8'd0, 2'b11, 4'd1, "R7 write word0 read word1");
    step(1'b0, 8'd0, 2'b00, 4'd0, "R2 ch0 bits1:0");
    check("R2 ch0 value", rd_word, 32'h0000_0003);
    step(1'b1, 8'd1, 2'b10, 4'd0, "R6 ch1 write-first");
    check("R2 ch1 bits3:2", rd_word, 32'h0000_000B);
    step(1'b1, 8'd16, 2'b01, 4'd1, "R6 ch16 write-first");
    check("R2 ch16 in word1", rd_word, 32'h0000_0001);
    step(1'b1, 8'd5, 2'b10, 4'd0, "R3 single field");
    check("R3 neighbours kept", rd_word, 32'h0000_080B);
    step(1'b0, 8'd5, 2'b01, 4'd0, "R4 unqualified ignored");
    check("R4 value kept", rd_word, 32'h0000_080B);
    // live view sweep, alternating status
    for (int c = 0; c < 256; c++) begin
      logic [1:0] s;
      s = (c % 2 == 0) ? 2'b10 : 2'b00;
      step(1'b1, c[7:0], s, c[7:4], "R6 live view");
    end
    for (int a = 0; a < 16; a++) step(1'b0, 8'hFF, 2'b11, a[3:0], "R4 readback after sweep");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic       v;
      logic [7:0] ch;
      logic [3:0] ra;
      v  = ($urandom % 4) != 0;
      ch = 8'($urandom);
      ra = ($urandom % 3 == 0) ? ch[7:4] : 4'($urandom);
      step(v, ch, 2'($urandom), ra,
           !v ? "R4 random idle" : (ra == ch[7:4]) ? "R6 random same word" : "R7 random other word");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        total++; bad++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule